// File: doc/BRIEF.md
# Expansion Bus Device Select Decoder

This block sits on the memory bus of an 8-bit processor and arbitrates up to eight expansion devices that share one ROM window. Software picks a device by writing a select byte to one register address. The block holds that byte in a select latch. It also decides whether the built-in math ROM, which overlaps the expansion ROM window, stays visible. That decision is a two-state overlay machine with two states. In `ROM_ON`, the built-in math ROM is visible. In `DEV_ROM`, an expansion device's ROM is visible instead. The transition `T_CLAIM` moves `ROM_ON` to `DEV_ROM` when an accepted select write is claimed by a device. The transition `T_RELEASE` moves `DEV_ROM` back to `ROM_ON` when an accepted select write is claimed by no device. Every other write leaves the state where it is.

A read of the select register does not return the latch. It returns a registered copy of the per-device interrupt lines. Other reads in the select page return the responding device's data, or 0xFF when no device answers. When the strap `ram_map_en` is high, two pages can be mapped to a local 512-byte RAM.

Top module: `xbus_sel_decoder`

## Requirements
- R1: While reset is held, `dev_sel` is 0x00, `fprom_en` is 1 and `irq` is 0, whatever the device interrupt lines carry. A read of 0xD1FF right after reset returns 0x00.
- R2: A write to 0xD1FF is accepted when its value is 0x00 or has exactly one bit set, and when it differs from the latch. An accepted value appears on `dev_sel` after the next clock edge.
- R3: A write to 0xD1FF with two or more bits set is ignored. `dev_sel` and `fprom_en` keep their values.
- R4: A write to 0xD1FF equal to the current latch has no effect on `fprom_en`, whatever `dev_claim` shows.
- R5: An accepted write is claimed when some bit is set in both the written value and `dev_claim` (bit n means device n). A claimed accepted write drives `fprom_en` to 0 after the edge.
- R6: An accepted write that is not claimed, including a write of 0x00, drives `fprom_en` to 1 after the edge.
- R7: A read of 0xD1FF returns the device interrupt lines as sampled at the previous clock edge, bit n for device n, and not the latch.
- R8: `irq` is active-high. It is 1 exactly when any registered interrupt status bit is 1.
- R9: A read of 0xD100 to 0xD1FE returns `dev_rdata` when `dev_rd_hit` is 1 and 0xFF otherwise. Reads outside the decoded pages, and cycles without `rd`, return 0xFF.
- R10: With `ram_map_en` at 1, addresses 0xD600 to 0xD7FF read and write 512 distinct bytes of local RAM. A write becomes readable after the clock edge.
- R11: With `ram_map_en` at 0, reads of 0xD600 to 0xD7FF return 0xFF and writes there leave the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, sampled on the clock edge |
| dev_claim | input | 8 | Per-device claim of the select value being written, valid in the write cycle |
| dev_irq | input | 8 | Per-device interrupt request lines |
| dev_rd_hit | input | 1 | A device answers the current select-page read |
| dev_rdata | input | 8 | Read data from the answering device |
| ram_map_en | input | 1 | Maps local RAM into 0xD600 to 0xD7FF |
| rdata | output | 8 | Read data to the CPU |
| fprom_en | output | 1 | Enable of the built-in math ROM at 0xD800 to 0xDFFF |
| dev_sel | output | 8 | One-hot (or zero) selected-device vector |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a write that repeats the latch value while `dev_claim` disagrees with how that value was first claimed. If the value-equality guard is missing, this write flips the overlay state. To provoke it, the bench first lands in `DEV_ROM` through a claimed write. It then writes the same byte again with every claim bit low, and checks that `fprom_en` stays at 0. It does the same for illegal multi-bit values sent with all claim bits high. Those values would take the overlay machine through `T_CLAIM` if the legality check were missing.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
    // Overlay state: which ROM is visible in the shared math-ROM window
    typedef enum logic {
        ROM_ON  = 1'b0,
        DEV_ROM = 1'b1
    } ovl_state_e;

    localparam logic [15:0] SEL_ADDR_DEF = 16'hD1FF;
    localparam logic [15:0] RAM_BASE_DEF = 16'hD600;
endpackage

// File: rtl/xbus_sel_ctrl.sv
`timescale 1ns/1ps
module xbus_sel_ctrl
    import xbus_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SEL_ADDR = SEL_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic [DATA_W-1:0] dev_claim,
    output logic [DATA_W-1:0] dev_sel,
    output logic              fprom_en
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    ovl_state_e        state_q, state_d;
    logic [DATA_W-1:0] sel_q;
    logic              sel_hit, legal, accept, claimed;

    assign sel_hit = wr && (addr == SEL_ADDR);
    assign legal   = ((wdata & (wdata - ONE)) == '0);
    assign accept  = sel_hit && legal && (wdata != sel_q);
    assign claimed = |(dev_claim & wdata);

    // Select latch
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (accept) sel_q <= wdata;
    end

    // Next-state logic: T_CLAIM and T_RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROM_ON:  if (accept && claimed)  state_d = DEV_ROM; // T_CLAIM
            DEV_ROM: if (accept && !claimed) state_d = ROM_ON;  // T_RELEASE
            default: state_d = ROM_ON;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ROM_ON;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        fprom_en = (state_q == ROM_ON);
        dev_sel  = sel_q;
    end
endmodule

// File: rtl/xbus_irq_stat.sv
`timescale 1ns/1ps
module xbus_irq_stat #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dev_irq,
    output logic [DATA_W-1:0] irq_stat,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) irq_stat <= '0;
        else        irq_stat <= dev_irq;
    end

    assign irq = |irq_stat;
endmodule

// File: rtl/xbus_page_ram.sv
`timescale 1ns/1ps
module xbus_page_ram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] a,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[a] <= d;
    end

    assign q = mem[a];
endmodule

// File: rtl/xbus_sel_decoder.sv
`timescale 1ns/1ps
module xbus_sel_decoder
    import xbus_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter int                RAM_AW   = 9,
    parameter logic [ADDR_W-1:0] SEL_ADDR = SEL_ADDR_DEF,
    parameter logic [ADDR_W-1:0] RAM_BASE = RAM_BASE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] dev_claim,
    input  logic [DATA_W-1:0] dev_irq,
    input  logic              dev_rd_hit,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              ram_map_en,
    output logic [DATA_W-1:0] rdata,
    output logic              fprom_en,
    output logic [DATA_W-1:0] dev_sel,
    output logic              irq
);
    localparam int PAGE_LSB = 8;

    logic [DATA_W-1:0] irq_stat;
    logic [DATA_W-1:0] ram_q;
    logic              in_sel_page, in_ram, ram_we;

    assign in_sel_page = (addr[ADDR_W-1:PAGE_LSB] == SEL_ADDR[ADDR_W-1:PAGE_LSB]);
    assign in_ram      = ram_map_en && (addr[ADDR_W-1:RAM_AW] == RAM_BASE[ADDR_W-1:RAM_AW]);
    assign ram_we      = wr && in_ram;

    xbus_sel_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr),
        .dev_claim(dev_claim), .dev_sel(dev_sel), .fprom_en(fprom_en)
    );

    xbus_irq_stat #(.DATA_W(DATA_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .irq_stat(irq_stat), .irq(irq)
    );

    xbus_page_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk(clk), .we(ram_we), .a(addr[RAM_AW-1:0]), .d(wdata), .q(ram_q)
    );

    always_comb begin
        rdata = '1;
        if (rd) begin
            if (addr == SEL_ADDR)           rdata = irq_stat;
            else if (in_sel_page)           rdata = dev_rd_hit ? dev_rdata : '1;
            else if (in_ram)                rdata = ram_q;
        end
    end
endmodule

// File: rtl/xbus_sel_decoder_chk.sv
`timescale 1ns/1ps
module xbus_sel_decoder_chk #(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'hD1FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              rd,
    input logic              wr,
    input logic [DATA_W-1:0] dev_claim,
    input logic [DATA_W-1:0] dev_irq,
    input logic              dev_rd_hit,
    input logic [DATA_W-1:0] rdata,
    input logic              fprom_en,
    input logic [DATA_W-1:0] dev_sel,
    input logic              irq
);
    logic sel_wr, ok_val, acc;
    assign sel_wr = wr && (addr == SEL_ADDR);
    assign ok_val = ($countones(wdata) <= 1);
    assign acc    = sel_wr && ok_val && (wdata != dev_sel);

    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel)); // R2
    AST_BAD_VALUE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !ok_val) |=> ($stable(dev_sel) && $stable(fprom_en))); // R3
    AST_SAME_VALUE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && (wdata == dev_sel)) |=> $stable(fprom_en)); // R4
    AST_CLAIM_HIDES_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && |(dev_claim & wdata)) |=> !fprom_en); // R5
    AST_NO_CLAIM_SHOWS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !(|(dev_claim & wdata))) |=> fprom_en); // R6
    AST_IRQ_TRACKS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq == (|$past(dev_irq)))); // R8
    AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((rd && addr == SEL_ADDR) -> (rdata == $past(dev_irq)))); // R7
    AST_EMPTY_PAGE_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr[ADDR_W-1:8] == SEL_ADDR[ADDR_W-1:8] && addr != SEL_ADDR && !dev_rd_hit)
        |-> (rdata == '1)); // R9
endmodule

bind xbus_sel_decoder xbus_sel_decoder_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_ADDR(SEL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
    .dev_claim(dev_claim), .dev_irq(dev_irq), .dev_rd_hit(dev_rd_hit),
    .rdata(rdata), .fprom_en(fprom_en), .dev_sel(dev_sel), .irq(irq)
);

// File: tb/tb_xbus_sel_decoder.sv
`timescale 1ns/1ps
module tb_xbus_sel_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  dev_claim = 8'h00;
    logic [7:0]  dev_irq = 8'h00;
    logic        dev_rd_hit = 1'b0;
    logic [7:0]  dev_rdata = 8'h00;
    logic        ram_map_en = 1'b0;
    logic [7:0]  rdata;
    logic        fprom_en;
    logic [7:0]  dev_sel;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xbus_sel_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
        .dev_claim(dev_claim), .dev_irq(dev_irq), .dev_rd_hit(dev_rd_hit),
        .dev_rdata(dev_rdata), .ram_map_en(ram_map_en), .rdata(rdata),
        .fprom_en(fprom_en), .dev_sel(dev_sel), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic [7:0] claim);
        @(negedge clk);
        addr = a; wdata = d; dev_claim = claim; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; dev_claim = 8'h00;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        dev_irq = 8'hA5;
        repeat (3) @(negedge clk);
        chk("R1 dev_sel in reset", dev_sel, 8'h00);
        chk("R1 fprom_en in reset", {7'd0, fprom_en}, 8'h01);
        chk("R1 irq in reset", {7'd0, irq}, 8'h00);
        dev_irq = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(16'hD1FF, v);
        chk("R1 status after reset", v, 8'h00);
    endtask

    task automatic t_select();
        bus_write(16'hD1FF, 8'h04, 8'h04);
        chk("R2 latch 04", dev_sel, 8'h04);
        chk("R5 claimed hides ROM", {7'd0, fprom_en}, 8'h00);
        bus_write(16'hD1FF, 8'h10, 8'h00);
        chk("R2 latch 10", dev_sel, 8'h10);
        chk("R6 unclaimed shows ROM", {7'd0, fprom_en}, 8'h01);
        bus_write(16'hD1FF, 8'h20, 8'h01);
        chk("R2 latch 20", dev_sel, 8'h20);
        chk("R5 claim bit must match value", {7'd0, fprom_en}, 8'h01);
    endtask

    task automatic t_invalid();
        bus_write(16'hD1FF, 8'h03, 8'hFF);
        chk("R3 two-bit value ignored sel", dev_sel, 8'h20);
        chk("R3 two-bit value ignored rom", {7'd0, fprom_en}, 8'h01);
        bus_write(16'hD1FF, 8'hFF, 8'hFF);
        chk("R3 all-ones value ignored sel", dev_sel, 8'h20);
        chk("R3 all-ones value ignored rom", {7'd0, fprom_en}, 8'h01);
    endtask

    task automatic t_same();
        bus_write(16'hD1FF, 8'h08, 8'h08);
        chk("R5 claim 08", {7'd0, fprom_en}, 8'h00);
        bus_write(16'hD1FF, 8'h08, 8'h00);
        chk("R4 repeat value keeps rom off", {7'd0, fprom_en}, 8'h00);
        chk("R4 repeat value keeps sel", dev_sel, 8'h08);
        bus_write(16'hD1FF, 8'h00, 8'hFF);
        chk("R6 zero write selects none", dev_sel, 8'h00);
        chk("R6 zero write shows ROM", {7'd0, fprom_en}, 8'h01);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        bus_write(16'hD1FF, 8'h02, 8'h02);
        @(negedge clk);
        dev_irq = 8'h81;
        @(negedge clk);
        chk("R8 irq high", {7'd0, irq}, 8'h01);
        bus_read(16'hD1FF, v);
        chk("R7 status not latch", v, 8'h81);
        dev_irq = 8'h00;
        @(negedge clk);
        chk("R8 irq low", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_page();
        logic [7:0] v;
        dev_rd_hit = 1'b0; dev_rdata = 8'h3C;
        bus_read(16'hD1A0, v);
        chk("R9 unclaimed page read", v, 8'hFF);
        dev_rd_hit = 1'b1;
        bus_read(16'hD1A0, v);
        chk("R9 claimed page read", v, 8'h3C);
        dev_rd_hit = 1'b0;
        bus_read(16'h1234, v);
        chk("R9 undecoded read", v, 8'hFF);
    endtask

    task automatic t_ram();
        logic [7:0] v;
        ram_map_en = 1'b0;
        bus_read(16'hD605, v);
        chk("R11 unmapped read", v, 8'hFF);
        ram_map_en = 1'b1;
        bus_write(16'hD605, 8'h5A, 8'h00);
        bus_write(16'hD705, 8'hA5, 8'h00);
        bus_read(16'hD605, v);
        chk("R10 low page", v, 8'h5A);
        bus_read(16'hD705, v);
        chk("R10 high page", v, 8'hA5);
        ram_map_en = 1'b0;
        bus_write(16'hD605, 8'h00, 8'h00);
        ram_map_en = 1'b1;
        bus_read(16'hD605, v);
        chk("R11 unmapped write dropped", v, 8'h5A);
        ram_map_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_select();
        t_invalid();
        t_same();
        t_irq();
        t_page();
        t_ram();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule